// File: doc/BRIEF.md
# GPIO Port with Input-Change Interrupt

This block is a single-register general purpose I/O port on a pipelined Wishbone slave bus. It drives 16 output wires and watches 16 input wires. A read of the one 32-bit register returns the input levels and the output levels together. A write sets the output wires.

The input wires may be asynchronous to the bus clock, so they pass through a two-flop synchronizer before anything uses them. The block compares each new synchronized sample with the one before it. If any bit differs, it raises its interrupt line for exactly one clock. There is no per-bit mask, and the interrupt is not held: an external interrupt controller latches it.

The pins have no high-impedance or pull control. The block always drives its outputs and only samples its inputs.

Top module: `gpio_ctl`

## Requirements
- R1: While reset is low, `o_gpio` is 0, `o_wb_ack` is 0 and `o_int` is 0.
- R2: `o_wb_stall` is always 0. Every clock in which `i_wb_cyc` and `i_wb_stb` are both high produces `o_wb_ack` high in the next clock, and no other clock does, so back-to-back requests give back-to-back acknowledges.
- R3: A write request (`i_wb_we` high) sets `o_gpio` to `i_wb_data[15:0]` in the clock after the request. Bits [31:16] of the write data have no effect.
- R4: `o_gpio` keeps its value in every clock that follows no write request. This includes clocks where `i_wb_stb` is high while `i_wb_cyc` is low.
- R5: A read request returns a word in the acknowledge clock. Bits [15:0] hold the `o_gpio` value at the request. Bits [31:16] hold the synchronized input, which is the value `i_gpio` had two clock edges before the request edge.
- R6: When `i_gpio` changes and then holds, `o_int` is high for exactly one clock. That clock starts at the second rising edge after the change.
- R7: Any change raises the same single pulse, whether it is a change of one bit or of several bits at once. No bit can be masked.
- R8: The input level present at the first clock edge after reset release is the baseline, so leaving reset with the inputs non-zero raises no pulse. A change that arrives after that first edge raises a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Bus and logic clock |
| i_rst_n | input | 1 | Synchronous active-low reset |
| i_wb_cyc | input | 1 | Bus cycle valid |
| i_wb_stb | input | 1 | Request strobe |
| i_wb_we | input | 1 | 1 = write, 0 = read |
| i_wb_data | input | 32 | Write data; bits [15:0] used |
| o_wb_stall | output | 1 | Always 0 |
| o_wb_ack | output | 1 | Request acknowledge, one clock after the strobe |
| o_wb_data | output | 32 | Read word {inputs, outputs} |
| i_gpio | input | 16 | Input wires, possibly asynchronous |
| o_gpio | output | 16 | Output wires |
| o_int | output | 1 | One-clock pulse on any input change |

## Verification
Acknowledge, read data and new output levels all appear one edge after the request edge. An input change is seen in the read word and on `o_int` two edges after it is applied, and the pulse falls after the third edge. A reference model in the bench updates on every rising edge using these latencies and keeps two samples of input history. All outputs are compared at the falling edge that follows, so each comparison lands on the cycle the requirement names. Directed cases count pulse lengths over a window and check the reset baseline with the inputs held high.

// File: rtl/gpio_pkg.sv
// gpio_pkg: shared constants and types for the GPIO port.
// Assumes a 32-bit bus word; the input and output widths are set at the top.
package gpio_pkg;

    localparam int unsigned GPIO_BUS_W = 32;

    // One bus request, as seen on a single clock edge.
    typedef struct packed {
        logic                  valid;
        logic                  write;
        logic [GPIO_BUS_W-1:0] wdata;
    } gpio_req_t;

endpackage

// File: rtl/gpio_sync.sv
// gpio_sync: multi-flop synchronizer for a bus of asynchronous inputs.
// It also carries a valid flag through a matching chain, so downstream
// logic knows when the last stage holds a real post-reset sample.
// Assumes STAGES >= 2 and that each bit may be sampled on its own.
module gpio_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         i_clk,
    input  logic         i_rst_n,
    input  logic [W-1:0] i_async,
    output logic [W-1:0] o_sync,
    output logic         o_valid
);

    logic [STAGES-1:0][W-1:0] stage_q;
    logic [STAGES-1:0]        vld_q;

    // Shift the input and its valid flag through the flop chain.
    always_ff @(posedge i_clk) begin
        if (!i_rst_n) begin
            stage_q <= '0;
            vld_q   <= '0;
        end else begin
            stage_q[0] <= i_async;
            vld_q[0]   <= 1'b1;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
                vld_q[s]   <= vld_q[s-1];
            end
        end
    end

    assign o_sync  = stage_q[STAGES-1];
    assign o_valid = vld_q[STAGES-1];

endmodule

// File: rtl/gpio_change.sv
// gpio_change: flags any difference between the current synchronized sample
// and the previous one. The pulse lasts one clock per change.
// Assumes i_sample is already synchronous and i_valid marks real samples.
module gpio_change #(
    parameter int unsigned W = 16
) (
    input  logic         i_clk,
    input  logic         i_rst_n,
    input  logic [W-1:0] i_sample,
    input  logic         i_valid,
    output logic         o_pulse
);

    logic [W-1:0] prev_q;
    logic         prev_vld_q;
    logic [W-1:0] diff;

    // Remember the previous sample and whether it was a real one.
    always_ff @(posedge i_clk) begin
        if (!i_rst_n) begin
            prev_q     <= '0;
            prev_vld_q <= 1'b0;
        end else begin
            prev_q     <= i_sample;
            prev_vld_q <= i_valid;
        end
    end

    // Compare only when both samples are real, so reset cannot fake a change.
    always_comb begin
        diff    = i_sample ^ prev_q;
        o_pulse = i_valid && prev_vld_q && (|diff);
    end

endmodule

// File: rtl/gpio_regif.sv
// gpio_regif: single-register bus slave for the GPIO port. It holds the
// output register and answers each request one clock later.
// Assumes IN_W + OUT_W <= bus width. Inputs sit above the outputs in the word.
module gpio_regif
    import gpio_pkg::*;
#(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned OUT_W = 16
) (
    input  logic                  i_clk,
    input  logic                  i_rst_n,
    input  gpio_req_t             i_req,
    input  logic [IN_W-1:0]       i_in_sync,
    output logic                  o_ack,
    output logic [GPIO_BUS_W-1:0] o_rdata,
    output logic [OUT_W-1:0]      o_out
);

    localparam int unsigned USED_W = IN_W + OUT_W;
    localparam int unsigned PAD_W  = GPIO_BUS_W - USED_W;

    logic [GPIO_BUS_W-1:0] word;

    // Build the readback word; pad the unused upper bits when widths are narrow.
    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {{PAD_W{1'b0}}, i_in_sync, o_out};
        end else begin : g_full
            assign word = {i_in_sync, o_out};
        end
    endgenerate

    // Acknowledge every request one clock later.
    always_ff @(posedge i_clk) begin
        if (!i_rst_n) o_ack <= 1'b0;
        else          o_ack <= i_req.valid;
    end

    // Capture the readback word at the request edge.
    always_ff @(posedge i_clk) begin
        if (!i_rst_n)         o_rdata <= '0;
        else if (i_req.valid) o_rdata <= word;
    end

    // Update the output register on writes, low bits only.
    always_ff @(posedge i_clk) begin
        if (!i_rst_n)                         o_out <= '0;
        else if (i_req.valid && i_req.write)  o_out <= i_req.wdata[OUT_W-1:0];
    end

endmodule

// File: rtl/gpio_ctl.sv
// gpio_ctl: GPIO port with one read/write register and an input-change
// interrupt. Inputs are synchronized, then compared sample to sample.
// Assumes a pipelined bus slave that never stalls and a single register.
module gpio_ctl
    import gpio_pkg::*;
#(
    parameter int unsigned IN_W        = 16,
    parameter int unsigned OUT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  i_clk,
    input  logic                  i_rst_n,
    input  logic                  i_wb_cyc,
    input  logic                  i_wb_stb,
    input  logic                  i_wb_we,
    input  logic [GPIO_BUS_W-1:0] i_wb_data,
    output logic                  o_wb_stall,
    output logic                  o_wb_ack,
    output logic [GPIO_BUS_W-1:0] o_wb_data,
    input  logic [IN_W-1:0]       i_gpio,
    output logic [OUT_W-1:0]      o_gpio,
    output logic                  o_int
);

    gpio_req_t       req;
    logic [IN_W-1:0] in_sync;
    logic            in_valid;

    // Collect the bus request fields for the register interface.
    always_comb begin
        req.valid = i_wb_cyc && i_wb_stb;
        req.write = i_wb_we;
        req.wdata = i_wb_data;
    end

    assign o_wb_stall = 1'b0;

    gpio_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .i_clk   (i_clk),
        .i_rst_n (i_rst_n),
        .i_async (i_gpio),
        .o_sync  (in_sync),
        .o_valid (in_valid)
    );

    gpio_change #(.W(IN_W)) u_change (
        .i_clk    (i_clk),
        .i_rst_n  (i_rst_n),
        .i_sample (in_sync),
        .i_valid  (in_valid),
        .o_pulse  (o_int)
    );

    gpio_regif #(.IN_W(IN_W), .OUT_W(OUT_W)) u_regif (
        .i_clk     (i_clk),
        .i_rst_n   (i_rst_n),
        .i_req     (req),
        .i_in_sync (in_sync),
        .o_ack     (o_wb_ack),
        .o_rdata   (o_wb_data),
        .o_out     (o_gpio)
    );

endmodule

// File: rtl/gpio_ctl_chk.sv
// gpio_ctl_chk: port-level properties of gpio_ctl, bound to every instance.
// The input-timing checks assume the default two-stage synchronizer.
module gpio_ctl_chk #(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned OUT_W = 16
) (
    input logic             i_clk,
    input logic             i_rst_n,
    input logic             i_wb_cyc,
    input logic             i_wb_stb,
    input logic             i_wb_we,
    input logic [31:0]      i_wb_data,
    input logic             o_wb_stall,
    input logic             o_wb_ack,
    input logic [31:0]      o_wb_data,
    input logic [IN_W-1:0]  i_gpio,
    input logic [OUT_W-1:0] o_gpio,
    input logic             o_int
);

    logic [2:0] since_rst;

    // Count edges since reset release, saturating, so history checks wait.
    always_ff @(posedge i_clk) begin
        if (!i_rst_n)             since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge i_clk)
        !i_rst_n |=> (!o_wb_ack && !o_int && o_gpio == '0)); // R1

    AST_NO_STALL: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        !o_wb_stall); // R2

    AST_ACK_AFTER_REQ: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        (i_wb_cyc && i_wb_stb) |=> o_wb_ack); // R2

    AST_NO_STRAY_ACK: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        !(i_wb_cyc && i_wb_stb) |=> !o_wb_ack); // R2

    AST_WRITE_SETS_OUT: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        (i_wb_cyc && i_wb_stb && i_wb_we) |=> (o_gpio == $past(i_wb_data[OUT_W-1:0]))); // R3

    AST_OUT_HOLDS: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        !(i_wb_cyc && i_wb_stb && i_wb_we) |=> $stable(o_gpio)); // R4

    AST_READ_OUT_FIELD: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        (i_wb_cyc && i_wb_stb && !i_wb_we) |=> (o_wb_data[OUT_W-1:0] == $past(o_gpio))); // R5

    AST_READ_IN_FIELD: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        (since_rst >= 3'd3 && i_wb_cyc && i_wb_stb && !i_wb_we)
        |=> (o_wb_data[OUT_W+IN_W-1:OUT_W] == $past(i_gpio, 3))); // R5

    AST_INT_HAS_CAUSE: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        o_int |-> ($past(i_gpio, 2) != $past(i_gpio, 3))); // R6

    AST_INT_ON_CHANGE: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        (since_rst >= 3'd4 && $past(i_gpio, 2) != $past(i_gpio, 3)) |-> o_int); // R7

endmodule

bind gpio_ctl gpio_ctl_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_gpio_ctl_chk (
    .i_clk      (i_clk),
    .i_rst_n    (i_rst_n),
    .i_wb_cyc   (i_wb_cyc),
    .i_wb_stb   (i_wb_stb),
    .i_wb_we    (i_wb_we),
    .i_wb_data  (i_wb_data),
    .o_wb_stall (o_wb_stall),
    .o_wb_ack   (o_wb_ack),
    .o_wb_data  (o_wb_data),
    .i_gpio     (i_gpio),
    .o_gpio     (o_gpio),
    .o_int      (o_int)
);

// File: tb/test_gpio_ctl.sv
`timescale 1ns/1ps
module test_gpio_ctl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cyc, stb, we;
    logic [31:0] wdat;
    logic        stall, ack, irq;
    logic [31:0] rdat;
    logic [15:0] gin, gout;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_ctl i_gpio_ctl (
        .i_clk(clk), .i_rst_n(rst_n), .i_wb_cyc(cyc), .i_wb_stb(stb),
        .i_wb_we(we), .i_wb_data(wdat), .o_wb_stall(stall), .o_wb_ack(ack),
        .o_wb_data(rdat), .i_gpio(gin), .o_gpio(gout), .o_int(irq)
    );

    // Reference model, advanced on each rising edge from the requirements.
    int          m_cnt;
    logic [15:0] m_h1, m_h2, m_out;
    logic        m_ack, m_rd, m_int;
    logic [31:0] m_rdat;

    function automatic logic [31:0] exp_word(logic [15:0] ins, logic [15:0] outs);
        return {ins, outs};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_h1 = '0; m_h2 = '0; m_out = '0;
            m_ack = 0; m_rd = 0; m_int = 0; m_rdat = '0;
        end else begin
            m_ack = cyc && stb;
            m_rd  = cyc && stb && !we;
            if (cyc && stb) m_rdat = exp_word(m_h2, m_out);
            if (cyc && stb && we) m_out = wdat[15:0];
            m_int = (m_cnt >= 2) && (m_h1 != m_h2);
            m_h2 = m_h1;
            m_h1 = gin;
            if (m_cnt < 100) m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 stall", {31'd0, stall}, 32'd0);
            chk("R2 ack", {31'd0, ack}, {31'd0, m_ack});
            chk("R3/R4 outputs", {16'd0, gout}, {16'd0, m_out});
            chk("R6 interrupt", {31'd0, irq}, {31'd0, m_int});
            if (m_rd) chk("R5 read word", rdat, m_rdat);
        end
    end

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cyc = 0; stb = 0; we = 0;
        end
    endtask

    // Count pulse clocks over a window following an input change.
    task automatic pulse_window(logic [15:0] newv, output int cnt, output int first);
        cnt = 0; first = -1;
        @(negedge clk);
        gin = newv;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (irq) begin
                cnt++;
                if (first < 0) first = k;
            end
        end
    endtask

    initial begin
        int cnt, first;
        rst_n = 0; cyc = 0; stb = 0; we = 0; wdat = '0; gin = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        chk("R1 reset out", {16'd0, gout}, 32'd0);
        chk("R1 reset ack", {31'd0, ack}, 32'd0);
        chk("R1 reset int", {31'd0, irq}, 32'd0);
        rst_n = 1;
        // R8: inputs held high across release give no pulse
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (irq) cnt++;
        end
        chk("R8 no pulse after reset", cnt, 0);

        // R6: single-bit change, one pulse at the second edge
        pulse_window(16'hFFFE, cnt, first);
        chk("R6 pulse length", cnt, 1);
        chk("R6 pulse cycle", first, 2);
        // R7: multi-bit change still one pulse
        pulse_window(16'h0F0E, cnt, first);
        chk("R7 multi-bit pulse", cnt, 1);

        // R3: upper write bits ignored
        @(negedge clk); cyc = 1; stb = 1; we = 1; wdat = 32'hABCD_1234;
        @(negedge clk); cyc = 0; stb = 0; we = 0;
        chk("R3 write low bits", {16'd0, gout}, 32'h0000_1234);
        @(negedge clk); cyc = 1; stb = 1; we = 0;
        @(negedge clk); cyc = 0; stb = 0;
        chk("R5 read after write", rdat, 32'h0F0E_1234);
        // R4: strobe without cycle changes nothing
        @(negedge clk); cyc = 0; stb = 1; we = 1; wdat = 32'h0000_5555;
        @(negedge clk); stb = 0; we = 0;
        chk("R4 no write without cyc", {16'd0, gout}, 32'h0000_1234);
        chk("R4 no ack without cyc", {31'd0, ack}, 32'd0);
        // R2: back-to-back strobes
        @(negedge clk); cyc = 1; stb = 1; we = 0;
        cnt = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (ack) cnt++;
        end
        cyc = 0; stb = 0;
        chk("R2 back-to-back acks", cnt, 3);
        idle(3);

        // Mid-run reset with inputs changing around the release (R1, R8)
        @(negedge clk); rst_n = 0; gin = 16'h1234;
        repeat (2) @(negedge clk);
        chk("R1 reset clears out", {16'd0, gout}, 32'd0);
        rst_n = 1;
        cnt = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (irq) cnt++;
        end
        chk("R8 baseline after reset", cnt, 0);

        // Random traffic checked by the model
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            cyc  = ($urandom % 8) != 0;
            stb  = $urandom % 2;
            we   = $urandom % 2;
            wdat = $urandom;
            if (($urandom % 4) == 0) gin = gin ^ 16'($urandom);
        end
        idle(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule